// File: doc/BRIEF.md
# SLIP Frame Receiver with Header Decode

This block sits behind a UART receiver and turns its byte stream into packets. Bytes arrive on a valid/ready input. The block removes SLIP escaping in-line and finds frame boundaries from the 0xC0 delimiter. It gathers a four-byte packet header and splits it into fields. It then passes the payload bytes on through a valid/ready output, and marks the final byte with a last flag. When a frame closes, the block raises a single-cycle accept or drop strobe. While that strobe is high, the decoded header fields and a drop reason code are valid at the outputs.

Reliable packets carry a sequence number. The block compares it with an expected value driven from outside. The comparison is made when the closing delimiter arrives, after the payload has already gone downstream. A downstream buffer therefore keeps each frame's payload until the strobe arrives, and it discards the payload on a drop. Back-pressure works through one output register. The input is ready whenever that register is empty or is being drained in the same cycle. A stalled output therefore stalls the whole input stream, including delimiters and header bytes. Frames whose length field exceeds the parameter `MAX_LEN` are abandoned as soon as the header is complete.

Top module: `slip_frame_rx`

## Requirements
- R1: Inside the header and the payload, the byte pair 0xDB 0xDC decodes to one data byte 0xC0, and the pair 0xDB 0xDD decodes to one data byte 0xDB.
- R2: If 0xDB is followed by any other byte inside the header or payload, the frame ends with a drop whose code is 1, and the block then waits for a new delimiter.
- R3: While the block waits for a frame, every byte other than 0xC0 is ignored, 0xDB included, and produces no strobe and no output byte.
- R4: An unescaped 0xC0 received during header collection restarts the collection from the first header byte, with no strobe.
- R5: Header byte 0 carries seq in bits 2:0, ack in bits 5:3, the CRC-present flag in bit 6 and the reliable flag in bit 7. Byte 1 carries the type in bits 3:0 and length bits 3:0 in bits 7:4. Byte 2 carries length bits 11:4. Byte 3 is collected but not interpreted. These fields are presented on the f_* outputs with each accept strobe.
- R6: After the header, exactly `length` decoded bytes come out on the output stream, in order. out_last is set on the final one. A zero length produces no output bytes, and the next byte must close the frame.
- R7: Types 0, 2, 4, 5 and 15 are recognised. Any other type skips the payload, and a closing 0xC0 then gives a drop with code 5.
- R8: If the byte after the payload, or after the header when no payload follows, is not 0xC0, the frame ends with a drop whose code is 2.
- R9: A frame with the reliable flag set whose seq differs from exp_seq at the closing delimiter is dropped with code 3. Frames without the flag are accepted whatever their seq.
- R10: A recognised frame whose length exceeds `MAX_LEN` is dropped with code 4 as soon as its fourth header byte is taken, and none of its payload is output.
- R11: frm_accept and frm_drop are each high for one cycle, in the cycle after the deciding byte is taken. They are never high together, and drop_why is nonzero exactly with frm_drop.
- R12: in_ready is low exactly when out_valid is high and out_ready is low. While stalled, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_seq | input | 3 | Expected sequence number for reliable frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Raw byte from the UART |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream can take the payload byte |
| out_data | output | 8 | Decoded payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| frm_accept | output | 1 | One-cycle strobe: frame accepted |
| frm_drop | output | 1 | One-cycle strobe: frame dropped |
| drop_why | output | 3 | Drop reason: 1 escape, 2 no end, 3 seq, 4 too long, 5 type |
| f_seq | output | 3 | Header seq field |
| f_ack | output | 3 | Header ack field |
| f_crc | output | 1 | Header CRC-present flag |
| f_rel | output | 1 | Header reliable flag |
| f_type | output | 4 | Header type field |
| f_len | output | 12 | Header length field |

## Verification
The assertions assume that reset is applied before the first frame. They also assume that the output stream's hold rule is only tested while the downstream side withholds out_ready, which the bench produces both by random withholding and by long forced stalls. The sequence property compares the accepted seq with exp_seq as it stood at the closing byte. The stimulus changes exp_seq only between frames, so a single sample is representative. The stimulus also covers escapes in the header, repeated delimiters, garbage between frames and lengths that use both length bytes.

// File: rtl/slip_rx_pkg.sv
package slip_rx_pkg;
  localparam logic [7:0] SLIP_END     = 8'hC0;
  localparam logic [7:0] SLIP_ESC     = 8'hDB;
  localparam logic [7:0] SLIP_ESC_END = 8'hDC;
  localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;
  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_BODY, ST_TAIL} rx_state_e;

  typedef enum logic [2:0] {
    DROP_NONE  = 3'd0,
    DROP_ESC   = 3'd1,
    DROP_NOEND = 3'd2,
    DROP_SEQ   = 3'd3,
    DROP_LONG  = 3'd4,
    DROP_TYPE  = 3'd5
  } drop_e;

  typedef struct packed {
    logic             rel;
    logic             crc;
    logic [2:0]       ack;
    logic [2:0]       seq;
    logic [3:0]       ptype;
    logic [LEN_W-1:0] len;
  } hdr_t;

  function automatic logic type_known(input logic [3:0] t);
    return (t == 4'd0) || (t == 4'd2) || (t == 4'd4) || (t == 4'd5) || (t == 4'd15);
  endfunction
endpackage

// File: rtl/slip_unescape.sv
module slip_unescape
  import slip_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] byte_i,
  output logic       raw_delim,
  output logic       d_valid,
  output logic [7:0] d_byte,
  output logic       d_err
);
  logic esc_q;

  assign raw_delim = (byte_i == SLIP_END) && !esc_q;

  always_comb begin
    d_valid = 1'b0;
    d_err   = 1'b0;
    d_byte  = byte_i;
    if (esc_q) begin
      if (byte_i == SLIP_ESC_END) begin
        d_valid = 1'b1;
        d_byte  = SLIP_END;
      end else if (byte_i == SLIP_ESC_ESC) begin
        d_valid = 1'b1;
        d_byte  = SLIP_ESC;
      end else begin
        d_err = 1'b1;
      end
    end else if (byte_i != SLIP_ESC) begin
      d_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) esc_q <= 1'b0;
    else if (take) esc_q <= !esc_q && (byte_i == SLIP_ESC);
  end
endmodule

// File: rtl/slip_hdr_collect.sv
module slip_hdr_collect
  import slip_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       store,
  input  logic [7:0] data,
  output logic       hdr_full,
  output hdr_t       hdr
);
  localparam int KEEP = HDR_BYTES - 1;
  localparam int IDX_W = $clog2(HDR_BYTES);

  logic [IDX_W-1:0] idx;
  logic [7:0]       hb [KEEP];

  assign hdr_full = store && (idx == IDX_W'(HDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) idx <= '0;
    else if (store) idx <= hdr_full ? '0 : idx + 1'b1;
  end

  for (genvar i = 0; i < KEEP; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) hb[i] <= '0;
      else if (store && idx == IDX_W'(i)) hb[i] <= data;
    end
  end

  assign hdr.rel   = hb[0][7];
  assign hdr.crc   = hb[0][6];
  assign hdr.ack   = hb[0][5:3];
  assign hdr.seq   = hb[0][2:0];
  assign hdr.ptype = hb[1][3:0];
  assign hdr.len   = {hb[2], hb[1][7:4]};
endmodule

// File: rtl/slip_out_stage.sv
module slip_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       dlast,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
      out_last  <= dlast;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/slip_frame_rx.sv
module slip_frame_rx
  import slip_rx_pkg::*;
#(
  parameter int MAX_LEN = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  exp_seq,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        frm_accept,
  output logic        frm_drop,
  output logic [2:0]  drop_why,
  output logic [2:0]  f_seq,
  output logic [2:0]  f_ack,
  output logic        f_crc,
  output logic        f_rel,
  output logic [3:0]  f_type,
  output logic [11:0] f_len
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

  rx_state_e        state;
  logic [LEN_W-1:0] rem;
  logic             bad_type_q;
  logic             take, esc_take;
  logic             raw_delim, d_valid, d_err;
  logic [7:0]       d_byte;
  logic             hdr_store, hdr_restart, hdr_full;
  hdr_t             hdr;
  logic             body_load;

  assign take     = in_valid && in_ready;
  assign esc_take = take && (state == ST_HDR || state == ST_BODY);

  slip_unescape u_unesc (
    .clk, .rst_n, .take(esc_take), .byte_i(in_data),
    .raw_delim, .d_valid, .d_byte, .d_err
  );

  assign hdr_restart = take && ((state == ST_IDLE && in_data == SLIP_END) ||
                                (state == ST_HDR && raw_delim));
  assign hdr_store   = take && state == ST_HDR && !raw_delim && d_valid;

  slip_hdr_collect u_hdr (
    .clk, .rst_n, .restart(hdr_restart), .store(hdr_store),
    .data(d_byte), .hdr_full, .hdr
  );

  assign body_load = take && state == ST_BODY && d_valid;

  slip_out_stage u_out (
    .clk, .rst_n, .load(body_load), .din(d_byte), .dlast(rem == LEN_W'(1)),
    .out_ready, .out_valid, .out_data, .out_last, .can_take(in_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rem        <= '0;
      bad_type_q <= 1'b0;
      frm_accept <= 1'b0;
      frm_drop   <= 1'b0;
      drop_why   <= DROP_NONE;
    end else begin
      frm_accept <= 1'b0;
      frm_drop   <= 1'b0;
      drop_why   <= DROP_NONE;
      if (take) begin
        unique case (state)
          ST_IDLE: if (in_data == SLIP_END) state <= ST_HDR;
          ST_HDR: begin
            if (raw_delim) begin
              state <= ST_HDR;
            end else if (d_err) begin
              frm_drop <= 1'b1;
              drop_why <= DROP_ESC;
              state    <= ST_IDLE;
            end else if (hdr_full) begin
              bad_type_q <= !type_known(hdr.ptype);
              rem        <= hdr.len;
              if (!type_known(hdr.ptype)) begin
                state <= ST_TAIL;
              end else if (hdr.len > LEN_LIMIT) begin
                frm_drop <= 1'b1;
                drop_why <= DROP_LONG;
                state    <= ST_IDLE;
              end else if (hdr.len == '0) begin
                state <= ST_TAIL;
              end else begin
                state <= ST_BODY;
              end
            end
          end
          ST_BODY: begin
            if (d_err) begin
              frm_drop <= 1'b1;
              drop_why <= DROP_ESC;
              state    <= ST_IDLE;
            end else if (d_valid) begin
              rem <= rem - 1'b1;
              if (rem == LEN_W'(1)) state <= ST_TAIL;
            end
          end
          ST_TAIL: begin
            state <= ST_IDLE;
            if (in_data != SLIP_END) begin
              frm_drop <= 1'b1;
              drop_why <= DROP_NOEND;
            end else if (bad_type_q) begin
              frm_drop <= 1'b1;
              drop_why <= DROP_TYPE;
            end else if (hdr.rel && hdr.seq != exp_seq) begin
              frm_drop <= 1'b1;
              drop_why <= DROP_SEQ;
            end else begin
              frm_accept <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign f_seq  = hdr.seq;
  assign f_ack  = hdr.ack;
  assign f_crc  = hdr.crc;
  assign f_rel  = hdr.rel;
  assign f_type = hdr.ptype;
  assign f_len  = hdr.len;
endmodule

// File: rtl/slip_frame_rx_chk.sv
module slip_frame_rx_chk #(
  parameter int MAX_LEN = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  exp_seq,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic        frm_accept,
  input logic        frm_drop,
  input logic [2:0]  drop_why,
  input logic [2:0]  f_seq,
  input logic        f_rel,
  input logic [11:0] f_len
);
  localparam logic [11:0] LIM = 12'(MAX_LEN);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_accept && frm_drop)); // R11
  AST_WHY_WITH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_drop |-> (drop_why >= 3'd1 && drop_why <= 3'd5)); // R11
  AST_WHY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_drop |-> drop_why == 3'd0); // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R12
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R12
  AST_SEQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_accept && f_rel) |-> f_seq == $past(exp_seq)); // R9
  AST_NO_OVERLONG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> f_len <= LIM); // R10
endmodule

bind slip_frame_rx slip_frame_rx_chk #(.MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .exp_seq(exp_seq), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .frm_accept(frm_accept), .frm_drop(frm_drop),
  .drop_why(drop_why), .f_seq(f_seq), .f_rel(f_rel), .f_len(f_len)
);

// File: tb/slip_frame_rx_tb_top.sv
module slip_frame_rx_tb_top;
  localparam int MAXL = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] exp_seq = 3'd0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, frm_accept, frm_drop, f_crc, f_rel;
  logic [7:0] out_data;
  logic [2:0] drop_why, f_seq, f_ack;
  logic [3:0] f_type;
  logic [11:0] f_len;

  always #5 clk = ~clk;

  slip_frame_rx #(.MAX_LEN(MAXL)) dut_i (
    .clk, .rst_n, .exp_seq, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_last,
    .frm_accept, .frm_drop, .drop_why,
    .f_seq, .f_ack, .f_crc, .f_rel, .f_type, .f_len
  );

  int checks = 0;
  int errors = 0;
  bit bp_on = 0;
  bit stall_mode = 0;
  logic [7:0] got_q[$];
  int ev_q[$];

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: behavioural, updated on every rising edge
  int mst = 0;        // 0 wait, 1 header, 2 body, 3 close
  bit mesc = 0;
  logic [7:0] hq[$];
  int mrem = 0;
  bit mbad = 0;
  bit m_ov = 0;
  logic [7:0] m_od = 0;
  bit m_ol = 0;
  bit m_acc = 0, m_drp = 0;
  int m_why = 0;
  int m_seq = 0, m_ack = 0, m_crc = 0, m_rel = 0, m_typ = 0, m_len = 0;

  always @(posedge clk) begin
    bit tk, dv, derr;
    logic [7:0] b, d;
    if (out_valid && out_ready) got_q.push_back(out_data);
    if (!rst_n) begin
      mst = 0; mesc = 0; m_ov = 0; m_acc = 0; m_drp = 0; m_why = 0; hq.delete();
    end else begin
      tk = in_valid && (!m_ov || out_ready);
      b = in_data;
      m_acc = 0; m_drp = 0; m_why = 0;
      if (m_ov && out_ready) m_ov = 0;
      if (tk) begin
        dv = 0; derr = 0; d = b;
        if (mst == 0) begin
          if (b == 8'hC0) begin mst = 1; hq.delete(); end
        end else if (mst == 1 && !mesc && b == 8'hC0) begin
          hq.delete();
        end else if (mst == 3) begin
          mst = 0;
          if (b != 8'hC0) begin m_drp = 1; m_why = 2; end
          else if (mbad) begin m_drp = 1; m_why = 5; end
          else if (m_rel == 1 && m_seq != int'(exp_seq)) begin m_drp = 1; m_why = 3; end
          else m_acc = 1;
        end else begin
          if (mesc) begin
            mesc = 0;
            if (b == 8'hDC) begin d = 8'hC0; dv = 1; end
            else if (b == 8'hDD) begin d = 8'hDB; dv = 1; end
            else derr = 1;
          end else if (b == 8'hDB) mesc = 1;
          else dv = 1;
          if (derr) begin
            m_drp = 1; m_why = 1; mst = 0;
          end else if (dv && mst == 1) begin
            hq.push_back(d);
            if (hq.size() == 4) begin
              m_rel = hq[0][7]; m_crc = hq[0][6]; m_ack = hq[0][5:3]; m_seq = hq[0][2:0];
              m_typ = hq[1][3:0]; m_len = hq[1][7:4] + 16 * hq[2];
              mbad = !(m_typ inside {0, 2, 4, 5, 15});
              if (mbad) mst = 3;
              else if (m_len > MAXL) begin m_drp = 1; m_why = 4; mst = 0; end
              else if (m_len == 0) mst = 3;
              else begin mst = 2; mrem = m_len; end
            end
          end else if (dv && mst == 2) begin
            m_ov = 1; m_od = d; m_ol = (mrem == 1);
            mrem--;
            if (mrem == 0) mst = 3;
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 out_valid", out_valid == m_ov, out_valid, m_ov);
      if (m_ov) begin
        chk("R6 out_data", out_data == m_od, out_data, m_od);
        chk("R6 out_last", out_last == m_ol, out_last, m_ol);
      end
      chk("R11 accept strobe", frm_accept == m_acc, frm_accept, m_acc);
      chk("R11 drop strobe", frm_drop == m_drp, frm_drop, m_drp);
      chk("R11 drop_why", int'(drop_why) == m_why, drop_why, m_why);
      if (m_acc) begin
        chk("R5 f_seq", int'(f_seq) == m_seq, f_seq, m_seq);
        chk("R5 f_ack", int'(f_ack) == m_ack, f_ack, m_ack);
        chk("R5 f_crc", int'(f_crc) == m_crc, f_crc, m_crc);
        chk("R5 f_rel", int'(f_rel) == m_rel, f_rel, m_rel);
        chk("R5 f_type", int'(f_type) == m_typ, f_type, m_typ);
        chk("R5 f_len", int'(f_len) == m_len, f_len, m_len);
      end
      if (frm_accept) ev_q.push_back(0);
      if (frm_drop) ev_q.push_back(int'(drop_why));
    end
  end

  task automatic sb(input logic [7:0] b);
    int waits = 0;
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (stall_mode) out_ready = (waits >= 4);
      else out_ready = !bp_on || ($urandom_range(0, 3) != 0);
      in_valid = 1'b1;
      in_data = b;
      #1;
      chk("R12 in_ready", in_ready == (!out_valid || out_ready), in_ready, !out_valid || out_ready);
      done = in_ready;
      waits++;
      @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
    end
  endtask

  task automatic hdr4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    sb(8'hC0); sb(a); sb(b); sb(c); sb(8'h5A);
  endtask

  task automatic expect_ev(input string tag, input int code);
    if (ev_q.size() == 0) chk(tag, 0, -1, code);
    else begin
      int e = ev_q.pop_front();
      chk(tag, e == code, e, code);
    end
  endtask

  task automatic expect_none(input string tag);
    chk(tag, ev_q.size() == 0, ev_q.size(), 0);
    ev_q.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset in_ready", in_ready == 1'b1, in_ready, 1);
    chk("R11 reset strobes", {frm_accept, frm_drop, out_valid} == 3'b000, {frm_accept, frm_drop, out_valid}, 0);
    rst_n = 1'b1;
    idle(2);

    // R6: unreliable zero-length frame, ack=3
    hdr4(8'h18, 8'h00, 8'h00); sb(8'hC0); idle(4);
    expect_ev("R6 zero length accept", 0);
    chk("R5 ack field", f_ack == 3'd3, f_ack, 3);

    // R5/R6: reliable type 2 len 3 seq 2 ack 1
    exp_seq = 3'd2; got_q.delete();
    hdr4(8'h8A, 8'h32, 8'h00); sb(8'h11); sb(8'h22); sb(8'h33); sb(8'hC0); idle(4);
    expect_ev("R9 matching seq accept", 0);
    chk("R6 byte count", got_q.size() == 3, got_q.size(), 3);
    if (got_q.size() == 3) chk("R6 payload order", {got_q[0], got_q[1], got_q[2]} == 24'h112233, {got_q[0], got_q[1], got_q[2]}, 24'h112233);
    chk("R5 fields", {f_rel, f_crc, f_seq, f_type, f_len} == {1'b1, 1'b0, 3'd2, 4'd2, 12'd3},
        {f_rel, f_crc, f_seq, f_type, f_len}, {1'b1, 1'b0, 3'd2, 4'd2, 12'd3});

    // R9: mismatched seq on reliable, ignored on unreliable
    exp_seq = 3'd5;
    hdr4(8'h82, 8'h12, 8'h00); sb(8'h44); sb(8'hC0); idle(4);
    expect_ev("R9 seq mismatch drop", 3);
    hdr4(8'h02, 8'h12, 8'h00); sb(8'h44); sb(8'hC0); idle(4);
    expect_ev("R9 unreliable ignores seq", 0);

    // R1: escapes in header byte 0 and in payload
    exp_seq = 3'd0; got_q.delete();
    sb(8'hC0); sb(8'hDB); sb(8'hDC); sb(8'h22); sb(8'h00); sb(8'h11);
    sb(8'hDB); sb(8'hDC); sb(8'hDB); sb(8'hDD); sb(8'hC0); idle(4);
    expect_ev("R1 escaped frame accept", 0);
    chk("R1 escaped header", {f_rel, f_crc} == 2'b11, {f_rel, f_crc}, 3);
    chk("R1 decoded count", got_q.size() == 2, got_q.size(), 2);
    if (got_q.size() == 2) chk("R1 decoded bytes", {got_q[0], got_q[1]} == 16'hC0DB, {got_q[0], got_q[1]}, 16'hC0DB);

    // R2: bad escape in payload, then R3: garbage ignored before next frame
    hdr4(8'h00, 8'h22, 8'h00); sb(8'hDB); sb(8'h01); idle(3);
    expect_ev("R2 bad escape drop", 1);
    sb(8'h55); sb(8'hDB); sb(8'h01); sb(8'hAA); idle(4);
    expect_none("R3 garbage ignored");
    hdr4(8'h00, 8'h00, 8'h00); sb(8'hC0); idle(4);
    expect_ev("R3 frame after garbage", 0);

    // R4: repeated delimiters and restart mid-header
    sb(8'hC0); sb(8'hC0); sb(8'h18); sb(8'hC0);
    sb(8'h28); sb(8'h00); sb(8'h00); sb(8'h77); sb(8'hC0); idle(4);
    expect_ev("R4 restart accept", 0);
    chk("R4 restarted ack", f_ack == 3'd5, f_ack, 5);

    // R7: unknown type
    hdr4(8'h00, 8'h07, 8'h00); sb(8'hC0); idle(4);
    expect_ev("R7 unknown type drop", 5);

    // R8: missing closing delimiter
    hdr4(8'h00, 8'h12, 8'h00); sb(8'h66); sb(8'h55); idle(4);
    expect_ev("R8 missing end drop", 2);

    // R10: length 257 > 256, no payload out
    got_q.delete();
    hdr4(8'h00, 8'h12, 8'h10); idle(3);
    expect_ev("R10 overlong drop", 4);
    sb(8'h01); sb(8'h02); idle(4);
    chk("R10 no payload", got_q.size() == 0, got_q.size(), 0);
    expect_none("R10 no further strobe");

    // R5: length spanning both bytes (21) under random back-pressure
    bp_on = 1; got_q.delete();
    hdr4(8'h38, 8'h54, 8'h01);
    for (int i = 0; i < 21; i++) sb(8'(i + 1));
    sb(8'hC0); idle(6);
    expect_ev("R5 long length accept", 0);
    chk("R5 twelve-bit length", f_len == 12'd21, f_len, 21);
    chk("R6 long count", got_q.size() == 21, got_q.size(), 21);
    bp_on = 0;

    // R12: forced stalls
    stall_mode = 1; got_q.delete();
    hdr4(8'h00, 8'h42, 8'h00); sb(8'hA1); sb(8'hA2); sb(8'hA3); sb(8'hA4); sb(8'hC0);
    stall_mode = 0; idle(6);
    expect_ev("R12 stalled frame accept", 0);
    chk("R12 stalled count", got_q.size() == 4, got_q.size(), 4);
    if (got_q.size() == 4) chk("R12 stalled last byte", got_q[3] == 8'hA4, got_q[3], 8'hA4);
    expect_none("R11 no stray strobes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule